// File: doc/BRIEF.md
# Destination Address Hash Filter Lookup Engine

This engine decides whether a 48-bit destination MAC address is present in a receive address filter table. The table has 2048 slots of 64 bits each and sits in an external synchronous RAM that returns read data one cycle after the read is issued. The engine folds the address into an 11-bit slot index and then probes slots one after another until it settles the command. Probing ends at a matching entry, at an empty entry, or when a fixed hop budget runs out. It reports the outcome with a one-cycle done pulse, along with a hit flag, a table-full flag and the slot where it stopped.

The same probe serves three commands, chosen by the `op` input. Code 00 is a lookup, code 01 an insert and code 10 a delete; code 11 is treated as a lookup. An insert writes a freshly encoded entry into the first empty or matching slot. A delete clears a matching entry. A lookup never writes. A command is accepted only while the engine is idle.

Top module: `mhf_engine`

## Requirements
- R1: The start slot is computed from the reversed address. Let the address be m[47:0]. L is m[31:0] with the bits of each byte reversed, and h0 = m[39]. Then slot[10:9] = L[3:2] and slot[8:0] = {L[14:8],L[1:0]} ^ L[23:15] ^ {h0,L[31:24]}.
- R2: An inserted entry has the following layout. Bit 0 is valid (set to 1), bit 1 is the skip flag and bit 2 is the destination flag. The remaining bits are placed as shown, with p = m[47:32] and q = m[31:0]:

  | Entry bits | Source bits |
  |---|---|
  | 18:15 | p[7:4] |
  | 14:11 | p[3:0] |
  | 10:7 | p[15:12] |
  | 6:3 | p[11:8] |
  | 31 | q[20] |
  | 30:27 | q[19:16] |
  | 26:23 | q[31:28] |
  | 22:19 | q[27:24] |
  | 50:47 | q[7:4] |
  | 46:43 | q[3:0] |
  | 42:39 | q[15:12] |
  | 38:35 | q[11:8] |
  | 34:32 | q[23:21] |

  All other bits are 0.
- R3: Successive probes read consecutive slots. Slot 2047 is followed by slot 0.
- R4: A probe that reads an entry with bit 0 clear ends the command without a hit, and `slot` reports that empty slot.
- R5: An entry matches when bits 63:32 are equal and bits 31:3 are equal to the encoding of the address. Bits 2:0 of a stored valid entry do not affect the match.
- R6: No command issues more than HOPS reads (default 12). A lookup that exhausts the budget reports no hit and returns the last slot probed.
- R7: An insert writes its encoded entry, with the given flags, to the empty or matching slot where it stops. It reports a hit only if the slot held a matching entry.
- R8: An insert that exhausts the hop budget reports full, with no hit and no RAM write.
- R9: A delete that finds a match writes 64'h0 to that slot and reports a hit. A delete that finds no match writes nothing.
- R10: The done pulse lasts one cycle. A command settled at its first probe has done visible 4 cycles after the cycle in which start was driven, and each additional probe adds 2 cycles. A start asserted while a command is in progress is ignored.
- R11: While reset is held and directly after it is released, done, hit, full, ram_rd_en and ram_wr_en are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Command request, sampled while idle |
| op | input | 2 | 00 lookup, 01 insert, 10 delete, 11 lookup |
| mac | input | 48 | Destination address |
| dst_flag | input | 1 | Destination flag stored by insert |
| skip_flag | input | 1 | Skip flag stored by insert |
| done | output | 1 | One-cycle result strobe |
| hit | output | 1 | A matching entry was found |
| full | output | 1 | Insert ran out of hops |
| slot | output | 11 | Slot where probing stopped |
| ram_rd_en | output | 1 | Table RAM read enable |
| ram_wr_en | output | 1 | Table RAM write enable |
| ram_addr | output | 11 | Table RAM address |
| ram_wdata | output | 64 | Table RAM write data |
| ram_rdata | input | 64 | Table RAM read data, one cycle after the read |

## Verification
The table is filled in two ways: by the engine's own inserts, and by the bench placing entries directly. The directly placed entries are either unrelated valid entries, which can never match, or near-copies of a real encoding that differ only in the high word. Lookups into an empty table at several addresses check the hash. Chains of unrelated entries check linear stepping, including a chain that runs off slot 2047, and a full run of twelve check the hop budget and the full error. The near-copies separate a comparison of the whole high word from a partial one. Re-inserting with different flags, and then looking up, shows that the control bits take no part in the match. Deletes of present and absent addresses, together with a start issued while the engine is busy, confirm that the engine writes exactly when the rules call for it.

// File: rtl/mhf_pkg.sv
package mhf_pkg;
  localparam int MAC_W   = 48;
  localparam int SLOT_W  = 11;
  localparam int WORD_W  = 32;
  localparam int ENTRY_W = 2 * WORD_W;

  localparam int VLD_BIT  = 0;
  localparam int SKIP_BIT = 1;
  localparam int DST_BIT  = 2;
  localparam int CTRL_W   = 3;

  localparam logic [ENTRY_W-1:0] MATCH_MASK = {{(ENTRY_W-CTRL_W){1'b1}}, {CTRL_W{1'b0}}};

  localparam logic [1:0] OP_LOOKUP = 2'b00;
  localparam logic [1:0] OP_INSERT = 2'b01;
  localparam logic [1:0] OP_DELETE = 2'b10;

  typedef enum logic [1:0] {
    S_IDLE,
    S_HASH,
    S_WAIT,
    S_EVAL
  } mhf_state_e;
endpackage

// File: rtl/mhf_hash.sv
module mhf_hash
  import mhf_pkg::*;
(
  input  logic [WORD_W-1:0] lo_word,
  input  logic              hi_bit,
  output logic [SLOT_W-1:0] start_slot
);
  localparam int BYTE_W = 8;
  localparam int FOLD_W = SLOT_W - 2;

  logic [WORD_W-1:0] lrev;
  logic [FOLD_W-1:0] f1, f2, f3;

  for (genvar g = 0; g < WORD_W; g++) begin : g_rev
    assign lrev[g] = lo_word[(g / BYTE_W) * BYTE_W + (BYTE_W - 1) - (g % BYTE_W)];
  end

  assign f1 = {lrev[14:8], lrev[1:0]};
  assign f2 = lrev[23:15];
  assign f3 = {hi_bit, lrev[31:24]};

  assign start_slot = {lrev[3:2], f1 ^ f2 ^ f3};
endmodule

// File: rtl/mhf_entry_codec.sv
module mhf_entry_codec
  import mhf_pkg::*;
(
  input  logic [MAC_W-1:0]   mac,
  input  logic               dst_flag,
  input  logic               skip_flag,
  input  logic [ENTRY_W-1:0] stored,
  output logic [ENTRY_W-1:0] fresh,
  output logic               stored_valid,
  output logic               stored_match
);
  logic [15:0]       hp;
  logic [WORD_W-1:0] lp;
  logic [WORD_W-1:0] lo_w, hi_w;

  assign hp = mac[47:32];
  assign lp = mac[31:0];

  always_comb begin
    lo_w = '0;
    lo_w[31]    = lp[20];
    lo_w[30:27] = lp[19:16];
    lo_w[26:23] = lp[31:28];
    lo_w[22:19] = lp[27:24];
    lo_w[18:15] = hp[7:4];
    lo_w[14:11] = hp[3:0];
    lo_w[10:7]  = hp[15:12];
    lo_w[6:3]   = hp[11:8];
    lo_w[DST_BIT]  = dst_flag;
    lo_w[SKIP_BIT] = skip_flag;
    lo_w[VLD_BIT]  = 1'b1;

    hi_w = '0;
    hi_w[18:15] = lp[7:4];
    hi_w[14:11] = lp[3:0];
    hi_w[10:7]  = lp[15:12];
    hi_w[6:3]   = lp[11:8];
    hi_w[2:0]   = lp[23:21];
  end

  assign fresh        = {hi_w, lo_w};
  assign stored_valid = stored[VLD_BIT];
  assign stored_match = ((stored ^ fresh) & MATCH_MASK) == '0;
endmodule

// File: rtl/mhf_engine.sv
module mhf_engine
  import mhf_pkg::*;
#(
  parameter int HOPS = 12
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic [1:0]         op,
  input  logic [MAC_W-1:0]   mac,
  input  logic               dst_flag,
  input  logic               skip_flag,
  output logic               done,
  output logic               hit,
  output logic               full,
  output logic [SLOT_W-1:0]  slot,
  output logic               ram_rd_en,
  output logic               ram_wr_en,
  output logic [SLOT_W-1:0]  ram_addr,
  output logic [ENTRY_W-1:0] ram_wdata,
  input  logic [ENTRY_W-1:0] ram_rdata
);
  localparam int HOP_W = $clog2(HOPS + 1);

  mhf_state_e        st;
  logic [MAC_W-1:0]  mac_q;
  logic [1:0]        op_q;
  logic              dst_q, skip_q;
  logic [SLOT_W-1:0] cur;
  logic [HOP_W-1:0]  hops;

  logic [SLOT_W-1:0]  hash_slot;
  logic [ENTRY_W-1:0] fresh;
  logic               ent_valid, ent_match;

  mhf_hash u_hash (
    .lo_word    (mac_q[31:0]),
    .hi_bit     (mac_q[39]),
    .start_slot (hash_slot)
  );

  mhf_entry_codec u_codec (
    .mac          (mac_q),
    .dst_flag     (dst_q),
    .skip_flag    (skip_q),
    .stored       (ram_rdata),
    .fresh        (fresh),
    .stored_valid (ent_valid),
    .stored_match (ent_match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      done      <= 1'b0;
      hit       <= 1'b0;
      full      <= 1'b0;
      slot      <= '0;
      ram_rd_en <= 1'b0;
      ram_wr_en <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
      mac_q     <= '0;
      op_q      <= OP_LOOKUP;
      dst_q     <= 1'b0;
      skip_q    <= 1'b0;
      cur       <= '0;
      hops      <= '0;
    end else begin
      done      <= 1'b0;
      ram_rd_en <= 1'b0;
      ram_wr_en <= 1'b0;
      case (st)
        S_IDLE: begin
          if (start) begin
            mac_q  <= mac;
            op_q   <= op;
            dst_q  <= dst_flag;
            skip_q <= skip_flag;
            st     <= S_HASH;
          end
        end
        S_HASH: begin
          cur       <= hash_slot;
          ram_addr  <= hash_slot;
          ram_rd_en <= 1'b1;
          hops      <= HOP_W'(1);
          st        <= S_WAIT;
        end
        S_WAIT: st <= S_EVAL;
        S_EVAL: begin
          if (!ent_valid || ent_match) begin
            done <= 1'b1;
            hit  <= ent_valid;
            full <= 1'b0;
            slot <= cur;
            st   <= S_IDLE;
            if (op_q == OP_INSERT) begin
              ram_wr_en <= 1'b1;
              ram_wdata <= fresh;
            end else if (op_q == OP_DELETE && ent_valid) begin
              ram_wr_en <= 1'b1;
              ram_wdata <= '0;
            end
          end else if (hops == HOP_W'(HOPS)) begin
            done <= 1'b1;
            hit  <= 1'b0;
            full <= (op_q == OP_INSERT);
            slot <= cur;
            st   <= S_IDLE;
          end else begin
            cur       <= cur + 1'b1;
            ram_addr  <= cur + 1'b1;
            ram_rd_en <= 1'b1;
            hops      <= hops + 1'b1;
            st        <= S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mhf_engine_chk.sv
module mhf_engine_chk
  import mhf_pkg::*;
#(
  parameter int HOPS = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              done,
  input logic              hit,
  input logic              full,
  input logic              ram_rd_en,
  input logic              ram_wr_en,
  input logic [SLOT_W-1:0] ram_addr
);
  localparam int CW = $clog2(HOPS + 1) + 1;

  logic [CW-1:0]     rd_cnt;
  logic [SLOT_W-1:0] last_rd;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_cnt  <= '0;
      last_rd <= '0;
    end else begin
      if (done) rd_cnt <= '0;
      else if (ram_rd_en) rd_cnt <= rd_cnt + 1'b1;
      if (ram_rd_en) last_rd <= ram_addr;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R10
  AST_RD_WR_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(ram_rd_en && ram_wr_en)); // R10
  AST_WRITE_AT_DONE: assert property (@(posedge clk) disable iff (rst)
    ram_wr_en |-> done); // R7
  AST_FULL_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
    (done && full) |-> (!ram_wr_en && !hit)); // R8
  AST_HOP_BUDGET: assert property (@(posedge clk) disable iff (rst)
    ram_rd_en |-> (rd_cnt < CW'(HOPS))); // R6
  AST_PROBE_STEP: assert property (@(posedge clk) disable iff (rst)
    (ram_rd_en && rd_cnt != '0) |-> (ram_addr == last_rd + 1'b1)); // R3
endmodule

bind mhf_engine mhf_engine_chk #(.HOPS(HOPS)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .done      (done),
  .hit       (hit),
  .full      (full),
  .ram_rd_en (ram_rd_en),
  .ram_wr_en (ram_wr_en),
  .ram_addr  (ram_addr)
);

// File: tb/mhf_engine_bench.sv
module mhf_engine_bench;
  localparam int NH = 12;
  localparam logic [63:0] JUNK = 64'hFFFF_FFFF_0000_0001;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [47:0] mac = '0;
  logic        dst_flag = 1'b0, skip_flag = 1'b0;
  logic        done, hit, full, ram_rd_en, ram_wr_en;
  logic [10:0] slot, ram_addr;
  logic [63:0] ram_wdata, ram_rdata;

  always #4 clk = ~clk;

  mhf_engine #(.HOPS(NH)) u_mhf_engine (
    .clk(clk), .rst(rst), .start(start), .op(op), .mac(mac),
    .dst_flag(dst_flag), .skip_flag(skip_flag), .done(done), .hit(hit),
    .full(full), .slot(slot), .ram_rd_en(ram_rd_en), .ram_wr_en(ram_wr_en),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  logic [63:0] mem [0:2047];
  logic [63:0] sh  [0:2047];

  always @(posedge clk) begin
    if (ram_rd_en) ram_rdata <= mem[ram_addr];
    if (ram_wr_en) mem[ram_addr] <= ram_wdata;
  end

  int n_chk = 0, n_bad = 0, n_done = 0, n_wr = 0;
  bit finished = 0;

  bit          q_hit[$];
  bit          q_full[$];
  logic [10:0] q_slot[$];
  string       q_req[$];

  task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] ref_hash(logic [47:0] m);
    logic [31:0] l;
    logic [8:0]  x;
    for (int b = 0; b < 4; b++)
      for (int k = 0; k < 8; k++) l[b*8+k] = m[b*8+7-k];
    x = {l[14:8], l[1:0]} ^ l[23:15] ^ {m[39], l[31:24]};
    return {l[3:2], x};
  endfunction

  function automatic logic [63:0] ref_entry(logic [47:0] m, bit d, bit s);
    logic [63:0] e;
    logic [15:0] p;
    logic [31:0] q;
    p = m[47:32];
    q = m[31:0];
    e = '0;
    e[0] = 1'b1; e[1] = s; e[2] = d;
    e[18:15] = p[7:4];   e[14:11] = p[3:0];
    e[10:7]  = p[15:12]; e[6:3]   = p[11:8];
    e[31] = q[20];       e[30:27] = q[19:16];
    e[26:23] = q[31:28]; e[22:19] = q[27:24];
    e[50:47] = q[7:4];   e[46:43] = q[3:0];
    e[42:39] = q[15:12]; e[38:35] = q[11:8];
    e[34:32] = q[23:21];
    return e;
  endfunction

  function automatic logic [47:0] find_mac(logic [10:0] target, logic [15:0] seed);
    logic [47:0] m;
    for (int i = 0; i < (1 << 20); i++) begin
      m = {seed, 32'(i) * 32'h9E37_79B1 ^ {seed, seed}};
      if (ref_hash(m) == target) return m;
    end
    return '0;
  endfunction

  task automatic model(logic [1:0] o, logic [47:0] m, bit d, bit s,
                       output bit eh, output bit ef, output logic [10:0] es);
    logic [10:0] p;
    logic [63:0] e, w;
    p = ref_hash(m);
    e = ref_entry(m, d, s);
    eh = 0; ef = 0; es = p;
    for (int n = 0; n < NH; n++) begin
      w = sh[p];
      es = p;
      if (!w[0]) begin
        if (o == 2'b01) sh[p] = e;
        return;
      end
      if (w[63:32] == e[63:32] && w[31:3] == e[31:3]) begin
        eh = 1;
        if (o == 2'b01) sh[p] = e;
        if (o == 2'b10) sh[p] = '0;
        return;
      end
      if (n == NH - 1) begin
        ef = (o == 2'b01);
        return;
      end
      p = p + 11'd1;
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (ram_wr_en) n_wr++;
      if (done) begin
        n_done++;
        if (q_hit.size() == 0) begin
          chk(0, "R10", "unexpected done", 64'd1, 64'd0);
        end else begin
          bit eh, ef;
          logic [10:0] es;
          string rq;
          eh = q_hit.pop_front(); ef = q_full.pop_front();
          es = q_slot.pop_front(); rq = q_req.pop_front();
          chk(hit == eh,   rq, "hit",  64'(hit),  64'(eh));
          chk(full == ef,  rq, "full", 64'(full), 64'(ef));
          chk(slot == es,  rq, "slot", 64'(slot), 64'(es));
        end
      end
    end
  end

  task automatic run_op(logic [1:0] o, logic [47:0] m, bit d, bit s, string rq, output int lat);
    bit eh, ef;
    logic [10:0] es;
    model(o, m, d, s, eh, ef, es);
    q_hit.push_back(eh); q_full.push_back(ef); q_slot.push_back(es); q_req.push_back(rq);
    @(negedge clk);
    start = 1; op = o; mac = m; dst_flag = d; skip_flag = s;
    @(negedge clk);
    start = 0;
    lat = 1;
    while (!done) begin
      @(negedge clk);
      lat++;
    end
    @(negedge clk);
  endtask

  task automatic put(logic [10:0] a, logic [63:0] v);
    mem[a] = v;
    sh[a] = v;
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 64'd0, 64'd1);
    summary();
  end

  initial begin
    logic [47:0] ma, mb, mc, md, me, mf, mg;
    logic [10:0] ha, hb, hd, hf;
    int lat, w0, d0;
    for (int i = 0; i < 2048; i++) begin
      mem[i] = '0;
      sh[i] = '0;
    end
    ram_rdata = '0;
    ma = find_mac(11'd100, 16'h1A2B);
    mb = find_mac(11'd500, 16'h3C4D);
    mc = find_mac(11'd2046, 16'h5E6F);
    md = find_mac(11'd1000, 16'h7081);
    me = find_mac(11'd1500, 16'h92A3);
    mf = find_mac(11'd1200, 16'hB4C5);
    mg = find_mac(11'd1700, 16'hD6E7);
    ha = ref_hash(ma); hb = ref_hash(mb); hd = ref_hash(md); hf = ref_hash(mf);

    repeat (3) @(negedge clk);
    chk(!done && !hit && !full && !ram_rd_en && !ram_wr_en, "R11", "outputs in reset",
        64'({done, hit, full, ram_rd_en, ram_wr_en}), 64'd0);
    rst = 0;
    @(negedge clk);
    chk(!done && !hit && !full && !ram_rd_en && !ram_wr_en, "R11", "outputs after reset",
        64'({done, hit, full, ram_rd_en, ram_wr_en}), 64'd0);

    // R1 R4: lookups into an empty table land on the hash slot, first probe
    run_op(2'b00, ma, 0, 0, "R1", lat);
    chk(lat == 4, "R10", "single-probe latency", 64'(lat), 64'd4);
    run_op(2'b00, mg, 0, 0, "R1", lat);
    run_op(2'b11, me, 0, 0, "R4", lat);

    // R7 R2: insert into empty slot
    w0 = n_wr;
    run_op(2'b01, ma, 1, 0, "R7", lat);
    chk(n_wr == w0 + 1, "R7", "one write on insert", 64'(n_wr - w0), 64'd1);
    chk(mem[ha] == ref_entry(ma, 1, 0), "R2", "stored encoding", mem[ha], ref_entry(ma, 1, 0));
    run_op(2'b00, ma, 0, 0, "R5", lat);

    // R5 R7: re-insert with other flags updates in place; match ignores bits 2:0
    run_op(2'b01, ma, 0, 1, "R7", lat);
    chk(mem[ha] == ref_entry(ma, 0, 1), "R2", "updated flags", mem[ha], ref_entry(ma, 0, 1));
    run_op(2'b00, ma, 1, 1, "R5", lat);

    // R5: entry equal except one high-word bit must not match
    put(hf, ref_entry(mf, 0, 0) ^ 64'h0010_0000_0000_0000);
    run_op(2'b00, mf, 0, 0, "R5", lat);
    chk(lat == 6, "R10", "two-probe latency", 64'(lat), 64'd6);

    // R3 R4: chain of unrelated valid entries
    for (int k = 0; k < 4; k++) put(hb + 11'(k), JUNK);
    run_op(2'b00, mb, 0, 0, "R3", lat);
    chk(lat == 12, "R10", "five-probe latency", 64'(lat), 64'd12);
    run_op(2'b01, mb, 0, 0, "R7", lat);
    chk(mem[hb + 11'd4] == ref_entry(mb, 0, 0), "R7", "insert after chain",
        mem[hb + 11'd4], ref_entry(mb, 0, 0));

    // R3: wrap from 2047 to 0
    put(11'd2046, JUNK);
    put(11'd2047, JUNK);
    run_op(2'b00, mc, 0, 0, "R3", lat);
    run_op(2'b01, mc, 1, 1, "R3", lat);
    chk(mem[0] == ref_entry(mc, 1, 1), "R3", "insert wrapped to slot 0", mem[0], ref_entry(mc, 1, 1));
    run_op(2'b00, mc, 0, 0, "R3", lat);

    // R6 R8: budget exhausted
    for (int k = 0; k < NH; k++) put(hd + 11'(k), JUNK);
    run_op(2'b00, md, 0, 0, "R6", lat);
    w0 = n_wr;
    run_op(2'b01, md, 0, 0, "R8", lat);
    chk(n_wr == w0, "R8", "no write when full", 64'(n_wr - w0), 64'd0);
    chk(mem[hd + 11'(NH)] == '0, "R8", "slot after budget untouched", mem[hd + 11'(NH)], 64'd0);

    // R9: delete present and absent
    run_op(2'b10, ma, 0, 0, "R9", lat);
    chk(mem[ha] == '0, "R9", "deleted entry zero", mem[ha], 64'd0);
    run_op(2'b00, ma, 0, 0, "R9", lat);
    w0 = n_wr;
    run_op(2'b10, me, 0, 0, "R9", lat);
    chk(n_wr == w0, "R9", "absent delete writes nothing", 64'(n_wr - w0), 64'd0);
    run_op(2'b10, mb, 0, 0, "R9", lat);
    run_op(2'b00, mb, 0, 0, "R9", lat);

    // R10: start while busy is ignored
    begin
      bit eh, ef;
      logic [10:0] es;
      model(2'b00, mg, 0, 0, eh, ef, es);
      q_hit.push_back(eh); q_full.push_back(ef); q_slot.push_back(es); q_req.push_back("R10");
      d0 = n_done; w0 = n_wr;
      @(negedge clk);
      start = 1; op = 2'b00; mac = mg;
      @(negedge clk);
      op = 2'b01; mac = me;
      @(negedge clk);
      start = 0;
      repeat (12) @(negedge clk);
      chk(n_done == d0 + 1, "R10", "one done for two starts", 64'(n_done - d0), 64'd1);
      chk(n_wr == w0, "R10", "busy insert ignored", 64'(n_wr - w0), 64'd0);
    end
    run_op(2'b00, me, 0, 0, "R10", lat);

    begin
      bit same = 1;
      for (int i = 0; i < 2048; i++) if (mem[i] !== sh[i]) same = 0;
      chk(same, "R9", "table contents match model", 64'(same), 64'd1);
    end
    chk(q_hit.size() == 0, "R10", "all results seen", 64'(q_hit.size()), 64'd0);
    summary();
  end
endmodule